// File: doc/BRIEF.md
# Scan Address Interrogator

This block lets a test controller find out which slot addresses are occupied by several bridge devices that share one backplane scan bus. Every device has an open-drain style data output. A device either pulls the line low or offers a weak one, so the line reads as the AND of everything that is driven, and it reads one when nothing drives it. When the controller loads the special interrogation instruction, each device sends the inverted copy of its slot address, least significant bit first. While it sends, it compares each bit it offers against the level it senses on the line. A device that offers a weak one and senses a zero has lost that round. It goes quiet until the next round. A device that sends its whole address without losing has been identified. It then goes silent until the next reset.

The controller repeats the interrogation instruction and reads one address per round, until the line reads all ones. This is also why slot address zero cannot be used: its inverted form is indistinguishable from an idle line. If any other instruction value is loaded, the devices that are still taking part leave interrogation. The block receives one-cycle strobes for the capture, shift and update phases of the instruction scan, plus the serial input bit. Its outputs are a drive-low request, an output enable, and its selection state.

Top module: `scan_addr_interrogator`

## Requirements
- R1: After reset the selection state is 0 (waiting for address) and the output enable is low.
- R2: An update strobe in state 0, when the instruction register holds 8'h3A, moves the state to 1 (contending). The value is shifted in from the serial input least significant bit first. No drive happens in state 0.
- R3: In state 1, a capture strobe loads the inverted slot address into the low ADDR_W bits of the instruction register. During the following shift, bit i of that inverted address appears on shift cycle i. A 0 is output as enable high with drive-low high. A 1 is output as enable high with drive-low low.
- R4: Shift cycles at position ADDR_W and beyond leave the output released. Serial input bits fill the instruction register from the top in every state.
- R5: If the device offers a weak one while the sensed line is 0, the state becomes 2 (lost) on the next cycle, and the output stays released for the rest of that shift.
- R6: A device in state 1 that sent all ADDR_W bits without losing moves to state 3 (retired) on an update strobe with 8'h3A.
- R7: A device in state 2 returns to state 1 on an update strobe with 8'h3A, and it contends again in the next shift.
- R8: When every device is retired, an interrogation shift reads all ones on the line.
- R9: State 3 is kept, and the output stays released, whatever instruction is updated, until reset.
- R10: An update strobe with any value other than 8'h3A moves a device in state 1 or 2 to state 0.
- R11: Among the contenders in a round, the winner is decided at the lowest bit position where their addresses differ. The device whose address has a 1 at that position wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| capIr | input | 1 | Capture phase strobe of the instruction scan |
| shiftIr | input | 1 | One shift cycle of the instruction scan |
| updIr | input | 1 | Update phase strobe of the instruction scan |
| tdi | input | 1 | Serial input bit |
| busIn | input | 1 | Level sensed on the shared data line |
| slotAddr | input | ADDR_W | Slot address of this device |
| tdoLow | output | 1 | Request to pull the line low |
| tdoEn | output | 1 | Output enable (weak one when tdoLow is low) |
| selState | output | 2 | 0 waiting for address, 1 contending, 2 lost, 3 retired |

## Verification
Errors in the internal state appear on the shared line within one interrogation round. A device stuck contending pulls bits low that belong to the winner, so the controller reads a corrupted address. A device that retires too early, or drops out wrongly, leaves an address missing or produces an all-ones read too soon. A wrong bit counter shows up in the same shift as drive on positions past ADDR_W. A wrong exit decision shows up in the selection state one cycle after the update strobe.

// File: rtl/sai_pkg.sv
package sai_pkg;
  typedef enum logic [1:0] {
    ST_WAIT_ADDR  = 2'd0,
    ST_CONTEND    = 2'd1,
    ST_LOST       = 2'd2,
    ST_RETIRED    = 2'd3
  } selState_t;

  typedef struct packed {
    logic capAddr;
    logic capIdle;
    logic shift;
  } dpStrobe_t;
endpackage

// File: rtl/sai_dpath.sv
module sai_dpath import sai_pkg::*; #(
  parameter int ADDR_W = 6,
  parameter int IR_W   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic              tdi,
  input  logic [ADDR_W-1:0] slotAddr,
  input  logic              driveEn,
  output logic [IR_W-1:0]   irVal,
  output logic              lsb,
  output logic              tdoLow
);
  localparam logic [IR_W-1:0] IDLE_PAT = IR_W'(1);
  localparam int PAD_W = IR_W - ADDR_W;

  logic [IR_W-1:0] shReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg <= IDLE_PAT;
    end else if (stb.capAddr) begin
      shReg <= {{PAD_W{1'b1}}, ~slotAddr};
    end else if (stb.capIdle) begin
      shReg <= IDLE_PAT;
    end else if (stb.shift) begin
      shReg <= {tdi, shReg[IR_W-1:1]};
    end
  end

  assign irVal  = shReg;
  assign lsb    = shReg[0];
  assign tdoLow = driveEn & ~shReg[0];

  // R3: capture in contention holds the inverted address
  p_capture_r3: assert property (@(posedge clk) disable iff (!rstN)
    stb.capAddr |=> shReg[ADDR_W-1:0] == ~$past(slotAddr));

  // R4: serial input enters at the top
  p_shiftin_r4: assert property (@(posedge clk) disable iff (!rstN)
    (stb.shift && !stb.capAddr && !stb.capIdle) |=> shReg[IR_W-1] == $past(tdi));
endmodule

// File: rtl/sai_ctrl.sv
module sai_ctrl import sai_pkg::*; #(
  parameter int              ADDR_W = 6,
  parameter int              IR_W   = 8,
  parameter logic [IR_W-1:0] OP     = 8'h3A
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            capIr,
  input  logic            shiftIr,
  input  logic            updIr,
  input  logic            busIn,
  input  logic            lsb,
  input  logic [IR_W-1:0] irVal,
  output dpStrobe_t       stb,
  output logic            tdoEn,
  output logic [1:0]      selState
);
  localparam int CNT_W = $clog2(IR_W + 1);
  localparam logic [CNT_W-1:0] ADDR_LIM = CNT_W'(ADDR_W);
  localparam logic [CNT_W-1:0] IR_LIM   = CNT_W'(IR_W);

  selState_t       state;
  logic            armed;
  logic [CNT_W-1:0] bitCnt;
  logic            isOp;
  logic            contend;

  assign isOp    = (irVal == OP);
  assign contend = (state == ST_CONTEND) && armed && (bitCnt < ADDR_LIM);
  assign tdoEn   = contend && shiftIr && !capIr;
  assign selState = state;

  always_comb begin
    stb.capAddr = capIr && (state == ST_CONTEND);
    stb.capIdle = capIr && (state != ST_CONTEND);
    stb.shift   = shiftIr && !capIr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_WAIT_ADDR;
      armed  <= 1'b0;
      bitCnt <= '0;
    end else if (capIr) begin
      bitCnt <= '0;
      armed  <= (state == ST_CONTEND);
    end else if (shiftIr) begin
      if (bitCnt < IR_LIM) bitCnt <= bitCnt + 1'b1;
      if (tdoEn && (busIn != lsb)) state <= ST_LOST;
    end else if (updIr) begin
      armed <= 1'b0;
      unique case (state)
        ST_WAIT_ADDR: if (isOp) state <= ST_CONTEND;
        ST_CONTEND: begin
          if (!isOp)                           state <= ST_WAIT_ADDR;
          else if (armed && bitCnt >= ADDR_LIM) state <= ST_RETIRED;
        end
        ST_LOST:      state <= isOp ? ST_CONTEND : ST_WAIT_ADDR;
        ST_RETIRED:   state <= ST_RETIRED;
        default:      state <= ST_WAIT_ADDR;
      endcase
    end
  end

  // R5: losing a bit silences the device from the next cycle
  p_lose_r5: assert property (@(posedge clk) disable iff (!rstN)
    (tdoEn && busIn != lsb) |=> (selState == 2'd2 && !tdoEn));

  // R9: retirement holds until reset
  p_retired_r9: assert property (@(posedge clk) disable iff (!rstN)
    (selState == 2'd3) |=> (selState == 2'd3 && !tdoEn));

  // R10: foreign instruction ends interrogation
  p_exit_r10: assert property (@(posedge clk) disable iff (!rstN)
    (updIr && !capIr && !shiftIr && (selState == 2'd1 || selState == 2'd2) && !isOp)
      |=> selState == 2'd0);

  // R2: no drive while waiting for an address
  p_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    (selState == 2'd0) |-> !tdoEn);
endmodule

// File: rtl/scan_addr_interrogator.sv
module scan_addr_interrogator import sai_pkg::*; #(
  parameter int              ADDR_W = 6,
  parameter int              IR_W   = 8,
  parameter logic [IR_W-1:0] OP     = 8'h3A
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              capIr,
  input  logic              shiftIr,
  input  logic              updIr,
  input  logic              tdi,
  input  logic              busIn,
  input  logic [ADDR_W-1:0] slotAddr,
  output logic              tdoLow,
  output logic              tdoEn,
  output logic [1:0]        selState
);
  dpStrobe_t       stb;
  logic [IR_W-1:0] irVal;
  logic            lsb;

  sai_ctrl #(.ADDR_W(ADDR_W), .IR_W(IR_W), .OP(OP)) u_ctrl (
    .clk(clk), .rstN(rstN), .capIr(capIr), .shiftIr(shiftIr), .updIr(updIr),
    .busIn(busIn), .lsb(lsb), .irVal(irVal), .stb(stb), .tdoEn(tdoEn),
    .selState(selState)
  );

  sai_dpath #(.ADDR_W(ADDR_W), .IR_W(IR_W)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .tdi(tdi), .slotAddr(slotAddr),
    .driveEn(tdoEn), .irVal(irVal), .lsb(lsb), .tdoLow(tdoLow)
  );
endmodule

// File: tb/scan_addr_interrogator_tb.sv
`timescale 1ns/1ps
module scan_addr_interrogator_tb;
  localparam int N = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic capIr = 1'b0, shiftIr = 1'b0, updIr = 1'b0, tdi = 1'b0;
  logic [5:0] addrV [N];
  logic [N-1:0] enV, lowV;
  logic [1:0] selV [N];
  logic busVal;
  int nChk = 0, nBad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  assign busVal = ~|(enV & lowV);

  for (genvar g = 0; g < N; g++) begin : g_dev
    scan_addr_interrogator u_dut (
      .clk(clk), .rstN(rstN), .capIr(capIr), .shiftIr(shiftIr), .updIr(updIr),
      .tdi(tdi), .busIn(busVal), .slotAddr(addrV[g]),
      .tdoLow(lowV[g]), .tdoEn(enV[g]), .selState(selV[g])
    );
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doReset(input logic [5:0] a0, input logic [5:0] a1, input logic [5:0] a2);
    addrV[0] = a0; addrV[1] = a1; addrV[2] = a2;
    @(negedge clk); rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulseCap();
    @(negedge clk); capIr = 1'b1;
    @(negedge clk); capIr = 1'b0;
  endtask

  task automatic pulseUpd();
    @(negedge clk); updIr = 1'b1;
    @(negedge clk); updIr = 1'b0;
  endtask

  task automatic shiftBits(input logic [7:0] val, output logic [7:0] rd, output logic late);
    late = 1'b0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      shiftIr = 1'b1; tdi = val[i];
      #1;
      rd[i] = busVal;
      if (i >= 6 && enV != '0) late = 1'b1;
    end
    @(negedge clk); shiftIr = 1'b0;
  endtask

  task automatic round(input logic [7:0] op, output logic [7:0] rd);
    logic late;
    pulseCap();
    shiftBits(op, rd, late);
    check(!late, "R4 drive past address", {31'd0, late}, 32'd0);
    pulseUpd();
  endtask

  function automatic void arbModel(input logic [2:0] act, output logic [7:0] rd, output logic [2:0] won);
    logic [2:0] cur = act;
    rd = 8'hFF;
    for (int i = 0; i < 6; i++) begin
      logic b = 1'b1;
      for (int d = 0; d < N; d++) if (cur[d]) b &= ~addrV[d][i];
      rd[i] = b;
      for (int d = 0; d < N; d++) if (cur[d] && !addrV[d][i] && !b) cur[d] = 1'b0;
    end
    won = cur;
  endfunction

  task automatic checkSel(input string req, input logic [1:0] e0, input logic [1:0] e1, input logic [1:0] e2);
    check(selV[0] == e0, req, {30'd0, selV[0]}, {30'd0, e0});
    check(selV[1] == e1, req, {30'd0, selV[1]}, {30'd0, e1});
    check(selV[2] == e2, req, {30'd0, selV[2]}, {30'd0, e2});
  endtask

  task automatic testReset();
    doReset(6'b010100, 6'b100000, 6'b000001);
    checkSel("R1 reset state", 2'd0, 2'd0, 2'd0);
    check(enV == '0, "R1 no drive", {29'd0, enV}, 32'd0);
  endtask

  task automatic testExample();
    logic [7:0] rd;
    logic late;
    doReset(6'b010100, 6'b100000, 6'b000001);
    round(8'h3A, rd);
    check(rd == 8'hFF, "R2 quiet entry", {24'd0, rd}, 32'hFF);
    checkSel("R2 enter contention", 2'd1, 2'd1, 2'd1);
    pulseCap();
    shiftBits(8'h3A, rd, late);
    check(rd == 8'b11111110, "R3 first address read", {24'd0, rd}, 32'hFE);
    check(!late, "R4 released past address", {31'd0, late}, 32'd0);
    checkSel("R5 losers", 2'd2, 2'd2, 2'd1);
    pulseUpd();
    checkSel("R6 R7 after update", 2'd1, 2'd1, 2'd3);
    round(8'h3A, rd);
    check(rd == 8'b11101011, "R7 second read", {24'd0, rd}, 32'hEB);
    checkSel("R6 second retire", 2'd3, 2'd1, 2'd3);
    round(8'h3A, rd);
    check(rd == 8'b11011111, "R7 third read", {24'd0, rd}, 32'hDF);
    round(8'h3A, rd);
    check(rd == 8'hFF, "R8 all ones", {24'd0, rd}, 32'hFF);
    checkSel("R8 all retired", 2'd3, 2'd3, 2'd3);
    round(8'h12, rd);
    check(rd == 8'hFF, "R9 silent", {24'd0, rd}, 32'hFF);
    checkSel("R9 retired kept", 2'd3, 2'd3, 2'd3);
  endtask

  task automatic testModel();
    logic [7:0] rd, expRd;
    logic [2:0] act, won, retired;
    doReset(6'b110000, 6'b101000, 6'b011001);
    round(8'h3A, rd);
    act = 3'b111; retired = 3'b000;
    for (int r = 0; r < 4; r++) begin
      arbModel(act, expRd, won);
      round(8'h3A, rd);
      check(rd == expRd, "R11 arbitration read", {24'd0, rd}, {24'd0, expRd});
      retired |= won; act &= ~won;
      for (int d = 0; d < N; d++)
        check(selV[d] == (retired[d] ? 2'd3 : 2'd1), "R11 state", {30'd0, selV[d]},
              retired[d] ? 32'd3 : 32'd1);
    end
  endtask

  task automatic testExit();
    logic [7:0] rd;
    doReset(6'b010100, 6'b100000, 6'b000001);
    round(8'h3A, rd);
    round(8'h3A, rd);
    round(8'h55, rd);
    checkSel("R10 exit", 2'd0, 2'd0, 2'd3);
    round(8'h3A, rd);
    check(rd == 8'hFF, "R2 no drive in wait", {24'd0, rd}, 32'hFF);
    checkSel("R2 re-enter", 2'd1, 2'd1, 2'd3);
    round(8'h3A, rd);
    check(rd == 8'b11101011, "R10 resumed read", {24'd0, rd}, 32'hEB);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChk++; nBad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    addrV[0] = '0; addrV[1] = '0; addrV[2] = '0;
    testReset();
    testExample();
    testModel();
    testExit();
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule